// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block moves an 8-bit accumulator CPU into and out of interrupt service. When the core asks it to enter an interrupt, it copies the caller's program counter, index register, accumulator and condition code register into its own context registers. It then writes those values as five bytes onto a stack in RAM, sets the interrupt mask bit and reads a two-byte vector to form the new program counter. When the core asks it to return, it reads the same five bytes back in reverse order and restores all four registers, including the old mask state.

The stack is a 64-byte region at the top of the low address page, from 0xC0 to 0xFF. A stack pointer that resets to 0xFF always stays inside this region and wraps at its ends. Request sources are ranked by index, and index 0 is the most urgent. The vector for source `i` is stored at `VEC_BASE + 2*i` (high byte) and `VEC_BASE + 2*i + 1` (low byte). The RAM is single-port and returns read data one clock after the address is presented.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset the stack pointer reads 0xFF, and `busy`, `done` and `mem_en` are low.
- R2: An accepted entry makes five RAM writes on consecutive cycles. They go to the current stack pointer and the four addresses below it, and carry PC[7:0], PC[15:8], X, A and CCR, in that order.
- R3: After entry, `ccr_out` equals the sampled `ccr_in` with bit 3 (the interrupt mask) set, and `x_out` and `a_out` equal the sampled inputs.
- R4: After the pushes, the block reads `VEC_BASE + 2*i` and then `VEC_BASE + 2*i + 1`. `pc_out` becomes {first byte, second byte}.
- R5: The source taken is the lowest-numbered set bit of `irq_pend` at acceptance, and it is reported on `grant_id`.
- R6: `entry_req` is ignored when `ccr_in` bit 3 is set or when `irq_pend` is zero. In that case there is no RAM access, `busy` and `done` stay low, and the stack pointer and register outputs do not change.
- R7: A return reads five bytes at stack pointer + 1 through + 5, in the order CCR, A, X, PC[15:8], PC[7:0]. All four registers are restored from these bytes, including bit 3.
- R8: Each push decrements the stack pointer and each pop increments it, wrapping within 0xC0..0xFF. A push at 0xC0 is followed by 0xFF, and a pop from 0xFF reads 0xC0.
- R9: `done` is a one-cycle pulse. It is high 8 cycles after the clock edge that accepts an entry, and 6 cycles after the edge that accepts a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| entry_req | input | 1 | Request to enter an interrupt, sampled while idle |
| ret_req | input | 1 | Request to return from an interrupt, sampled while idle; wins over `entry_req` |
| irq_pend | input | NUM_SRC | Pending request per source, bit 0 most urgent |
| pc_in | input | 16 | Program counter of the interrupted code |
| x_in | input | 8 | Index register of the interrupted code |
| a_in | input | 8 | Accumulator of the interrupted code |
| ccr_in | input | 8 | Condition codes; bit 3 is the interrupt mask |
| pc_out | output | 16 | Program counter after the sequence |
| x_out | output | 8 | Index register after the sequence |
| a_out | output | 8 | Accumulator after the sequence |
| ccr_out | output | 8 | Condition codes after the sequence |
| sp_out | output | SP_W | Current stack pointer |
| grant_id | output | GID_W | Source taken by the last entry |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when the outputs are final |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write when high, read when low |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one cycle after a read access |

## Verification
The properties rely on three things about the inputs: RAM read data arrives exactly one cycle after the read strobe, every stack address has a zero upper byte, and no vector lies in the low page. The timing and priority checks also assume that requests do not overlap. The stimulus respects all of this. Its RAM model registers read data on the clock edge, and it keeps the vector table at 0xFFF0. Each request is held for a single cycle and is issued only after the previous sequence has finished. A return is issued only when a frame the bench pushed is still on the stack and has not been overwritten by wrap-around.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int DATA_W      = 8;
  localparam int PC_W        = 2 * DATA_W;
  localparam int CCR_I_BIT   = 3;
  localparam int FRAME_BYTES = 5;
  localparam int STEP_W      = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VEC,
    ST_POP,
    ST_POPL,
    ST_FIN
  } seq_state_t;

  // Push order is the slot number; pops run from the highest slot downwards.
  typedef enum logic [2:0] {
    SLOT_PCL = 3'd0,
    SLOT_PCH = 3'd1,
    SLOT_X   = 3'd2,
    SLOT_A   = 3'd3,
    SLOT_CCR = 3'd4
  } slot_t;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N    = 4,
  parameter int ID_W = 2
) (
  input  logic [N-1:0]    pend,
  output logic            any,
  output logic [ID_W-1:0] id
);

  // Lowest index wins: scan downwards so the last hit is the smallest index.
  always_comb begin
    any = |pend;
    id  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        id = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_sp_unit.sv
module irq_sp_unit #(
  parameter int SP_W      = 8,
  parameter int WRAP_BITS = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_up
);

  localparam int HI_W = SP_W - WRAP_BITS;

  logic [WRAP_BITS-1:0] low_q;
  logic [WRAP_BITS-1:0] low_d;
  logic [WRAP_BITS-1:0] low_inc;

  assign low_inc = low_q + WRAP_BITS'(1);

  always_comb begin
    low_d = low_q;
    if (push) begin
      low_d = low_q - WRAP_BITS'(1);
    end else if (pop) begin
      low_d = low_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '1;
    end else if (push || pop) begin
      low_q <= low_d;
    end
  end

  generate
    if (HI_W > 0) begin : g_region
      assign sp    = {{HI_W{1'b1}}, low_q};
      assign sp_up = {{HI_W{1'b1}}, low_inc};
    end else begin : g_full
      assign sp    = low_q;
      assign sp_up = low_inc;
    end
  endgenerate

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       entry_req,
  input  logic       ret_req,
  input  logic       take_ok,
  output logic       accept_entry,
  output logic       push_en,
  output slot_t      push_slot,
  output logic       set_mask,
  output logic       vec_rd,
  output logic       vec_lo,
  output logic       vec_cap_hi,
  output logic       vec_cap_lo,
  output logic       pop_en,
  output logic       cap_en,
  output slot_t      cap_slot,
  output logic       busy,
  output logic       done,
  output seq_state_t state_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FRAME_BYTES - 1);

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q,  step_d;

  always_comb begin
    state_d      = state_q;
    step_d       = step_q;
    accept_entry = 1'b0;
    push_en      = 1'b0;
    push_slot    = slot_t'(step_q);
    set_mask     = 1'b0;
    vec_rd       = 1'b0;
    vec_lo       = 1'b0;
    vec_cap_hi   = 1'b0;
    vec_cap_lo   = 1'b0;
    pop_en       = 1'b0;
    cap_en       = 1'b0;
    cap_slot     = SLOT_PCL;
    done         = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ret_req) begin
          state_d = ST_POP;
          step_d  = '0;
        end else if (entry_req && take_ok) begin
          accept_entry = 1'b1;
          state_d      = ST_PUSH;
          step_d       = '0;
        end
      end
      ST_PUSH: begin
        push_en = 1'b1;
        if (step_q == LAST_STEP) begin
          set_mask = 1'b1;
          state_d  = ST_VEC;
          step_d   = '0;
        end else begin
          step_d = step_q + STEP_W'(1);
        end
      end
      ST_VEC: begin
        step_d = step_q + STEP_W'(1);
        if (step_q == STEP_W'(0)) begin
          vec_rd = 1'b1;
        end else if (step_q == STEP_W'(1)) begin
          vec_rd     = 1'b1;
          vec_lo     = 1'b1;
          vec_cap_hi = 1'b1;
        end else begin
          vec_cap_lo = 1'b1;
          state_d    = ST_FIN;
        end
      end
      ST_POP: begin
        pop_en = 1'b1;
        if (step_q != STEP_W'(0)) begin
          cap_en   = 1'b1;
          cap_slot = slot_t'(STEP_W'(FRAME_BYTES) - step_q);
        end
        if (step_q == LAST_STEP) begin
          state_d = ST_POPL;
        end else begin
          step_d = step_q + STEP_W'(1);
        end
      end
      ST_POPL: begin
        cap_en   = 1'b1;
        cap_slot = SLOT_PCL;
        state_d  = ST_FIN;
      end
      ST_FIN: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign state_o = state_q;

endmodule

// File: rtl/irq_ctx_file.sv
module irq_ctx_file
  import irq_seq_pkg::*;
#(
  parameter int GID_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] ccr_in,
  input  logic [GID_W-1:0]  gid_in,
  input  logic              set_mask,
  input  logic              vec_cap_hi,
  input  logic              vec_cap_lo,
  input  logic              cap_en,
  input  slot_t             cap_slot,
  input  logic [DATA_W-1:0] rdata,
  input  slot_t             rd_slot,
  output logic [DATA_W-1:0] rd_byte,
  output logic [PC_W-1:0]   pc_q,
  output logic [DATA_W-1:0] x_q,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] ccr_q,
  output logic [GID_W-1:0]  gid_q
);

  logic [PC_W-1:0]   pc_d;
  logic [DATA_W-1:0] x_d, a_d, ccr_d;
  logic [GID_W-1:0]  gid_d;
  logic              upd;

  assign upd = load | set_mask | vec_cap_hi | vec_cap_lo | cap_en;

  always_comb begin
    pc_d  = pc_q;
    x_d   = x_q;
    a_d   = a_q;
    ccr_d = ccr_q;
    gid_d = gid_q;
    if (load) begin
      pc_d  = pc_in;
      x_d   = x_in;
      a_d   = a_in;
      ccr_d = ccr_in;
      gid_d = gid_in;
    end
    if (set_mask) begin
      ccr_d[CCR_I_BIT] = 1'b1;
    end
    if (vec_cap_hi) begin
      pc_d[PC_W-1:DATA_W] = rdata;
    end
    if (vec_cap_lo) begin
      pc_d[DATA_W-1:0] = rdata;
    end
    if (cap_en) begin
      unique case (cap_slot)
        SLOT_CCR: ccr_d               = rdata;
        SLOT_A:   a_d                 = rdata;
        SLOT_X:   x_d                 = rdata;
        SLOT_PCH: pc_d[PC_W-1:DATA_W] = rdata;
        default:  pc_d[DATA_W-1:0]    = rdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      x_q   <= '0;
      a_q   <= '0;
      ccr_q <= '0;
      gid_q <= '0;
    end else if (upd) begin
      pc_q  <= pc_d;
      x_q   <= x_d;
      a_q   <= a_d;
      ccr_q <= ccr_d;
      gid_q <= gid_d;
    end
  end

  always_comb begin
    unique case (rd_slot)
      SLOT_PCH: rd_byte = pc_q[PC_W-1:DATA_W];
      SLOT_X:   rd_byte = x_q;
      SLOT_A:   rd_byte = a_q;
      SLOT_CCR: rd_byte = ccr_q;
      default:  rd_byte = pc_q[DATA_W-1:0];
    endcase
  end

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int          NUM_SRC   = 4,
  parameter int          AW        = 16,
  parameter logic [15:0] VEC_BASE  = 16'hFFF0,
  parameter int          SP_W      = 8,
  parameter int          WRAP_BITS = 6,
  localparam int         GID_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               entry_req,
  input  logic               ret_req,
  input  logic [NUM_SRC-1:0] irq_pend,
  input  logic [15:0]        pc_in,
  input  logic [7:0]         x_in,
  input  logic [7:0]         a_in,
  input  logic [7:0]         ccr_in,
  output logic [15:0]        pc_out,
  output logic [7:0]         x_out,
  output logic [7:0]         a_out,
  output logic [7:0]         ccr_out,
  output logic [SP_W-1:0]    sp_out,
  output logic [GID_W-1:0]   grant_id,
  output logic               busy,
  output logic               done,
  output logic               mem_en,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata
);

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic             any_pend;
  logic [GID_W-1:0] pick_id;
  logic             take_ok;
  logic             accept_entry;
  logic             push_en, pop_en, set_mask;
  logic             vec_rd, vec_lo, vec_cap_hi, vec_cap_lo;
  logic             cap_en;
  slot_t            push_slot, cap_slot;
  seq_state_t       seq_state;
  logic             vec_phase;
  logic [SP_W-1:0]  sp_cur, sp_up;
  logic [AW-1:0]    vec_addr;

  irq_prio_pick #(
    .N    (NUM_SRC),
    .ID_W (GID_W)
  ) u_pick (
    .pend (irq_pend),
    .any  (any_pend),
    .id   (pick_id)
  );

  assign take_ok = any_pend & ~ccr_in[CCR_I_BIT];

  irq_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .entry_req    (entry_req),
    .ret_req      (ret_req),
    .take_ok      (take_ok),
    .accept_entry (accept_entry),
    .push_en      (push_en),
    .push_slot    (push_slot),
    .set_mask     (set_mask),
    .vec_rd       (vec_rd),
    .vec_lo       (vec_lo),
    .vec_cap_hi   (vec_cap_hi),
    .vec_cap_lo   (vec_cap_lo),
    .pop_en       (pop_en),
    .cap_en       (cap_en),
    .cap_slot     (cap_slot),
    .busy         (busy),
    .done         (done),
    .state_o      (seq_state)
  );

  irq_sp_unit #(
    .SP_W      (SP_W),
    .WRAP_BITS (WRAP_BITS)
  ) u_sp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (push_en),
    .pop   (pop_en),
    .sp    (sp_cur),
    .sp_up (sp_up)
  );

  irq_ctx_file #(
    .GID_W (GID_W)
  ) u_ctx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (accept_entry),
    .pc_in      (pc_in),
    .x_in       (x_in),
    .a_in       (a_in),
    .ccr_in     (ccr_in),
    .gid_in     (pick_id),
    .set_mask   (set_mask),
    .vec_cap_hi (vec_cap_hi),
    .vec_cap_lo (vec_cap_lo),
    .cap_en     (cap_en),
    .cap_slot   (cap_slot),
    .rdata      (mem_rdata),
    .rd_slot    (push_slot),
    .rd_byte    (mem_wdata),
    .pc_q       (pc_out),
    .x_q        (x_out),
    .a_q        (a_out),
    .ccr_q      (ccr_out),
    .gid_q      (grant_id)
  );

  assign vec_addr  = AW'(VEC_BASE) + AW'({grant_id, 1'b0}) + AW'(vec_lo);
  assign vec_phase = (seq_state == ST_VEC);

  always_comb begin
    mem_en   = push_en | pop_en | vec_rd;
    mem_we   = push_en;
    mem_addr = vec_addr;
    if (push_en) begin
      mem_addr = AW'(sp_cur);
    end else if (pop_en) begin
      mem_addr = AW'(sp_up);
    end
  end

  assign sp_out = sp_cur;

endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk #(
  parameter int NUM_SRC = 4,
  parameter int AW      = 16,
  parameter int SP_W    = 8,
  parameter int GID_W   = 2
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               entry_req,
  input logic               ret_req,
  input logic [NUM_SRC-1:0] irq_pend,
  input logic [7:0]         ccr_in,
  input logic [7:0]         ccr_out,
  input logic [SP_W-1:0]    sp_out,
  input logic [GID_W-1:0]   grant_id,
  input logic               busy,
  input logic               done,
  input logic               mem_en,
  input logic               mem_we,
  input logic [AW-1:0]      mem_addr,
  input logic               accept_entry,
  input logic               vec_phase
);

  localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

  // R2: every push targets the current stack pointer.
  p_push_at_sp_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_en && mem_we) |-> (mem_addr == AW'(sp_out)));

  // R8: a push moves the pointer down by one inside the wrap region.
  p_push_dec_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_en && mem_we) |=> (sp_out[5:0] == $past(sp_out[5:0]) - 6'd1));

  // R7: a stack read leaves the pointer on the address just read.
  p_pop_addr_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_en && !mem_we && (mem_addr[AW-1:8] == '0)) |=> (AW'(sp_out) == $past(mem_addr)));

  // R3: the mask bit is already set while the vector is fetched.
  p_mask_in_vec_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_phase |-> ccr_out[3]);

  // R5: the granted source was pending and nothing more urgent was.
  p_grant_prio_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept_entry |=> ((($past(irq_pend) >> grant_id) & ONE) == ONE)
                  && (($past(irq_pend) & ((ONE << grant_id) - ONE)) == '0));

  // R6: a masked entry request does not start a sequence.
  p_masked_ignored_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && entry_req && !ret_req && ccr_in[3]) |=> !busy);

  // R6: no RAM traffic while idle.
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> !mem_en);

  // R9: done lasts a single cycle.
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

endmodule

bind irq_stack_seq irq_stack_seq_chk #(
  .NUM_SRC (NUM_SRC),
  .AW      (AW),
  .SP_W    (SP_W),
  .GID_W   (GID_W)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .entry_req    (entry_req),
  .ret_req      (ret_req),
  .irq_pend     (irq_pend),
  .ccr_in       (ccr_in),
  .ccr_out      (ccr_out),
  .sp_out       (sp_out),
  .grant_id     (grant_id),
  .busy         (busy),
  .done         (done),
  .mem_en       (mem_en),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .accept_entry (accept_entry),
  .vec_phase    (vec_phase)
);

// File: tb/irq_stack_seq_test.sv
module irq_stack_seq_test;

  localparam int          NSRC  = 4;
  localparam logic [15:0] VBASE = 16'hFFF0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        entry_req, ret_req;
  logic [3:0]  irq_pend;
  logic [15:0] pc_in;
  logic [7:0]  x_in, a_in, ccr_in;
  logic [15:0] pc_out;
  logic [7:0]  x_out, a_out, ccr_out, sp_out;
  logic [1:0]  grant_id;
  logic        busy, done, mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  irq_stack_seq #(.NUM_SRC(NSRC), .VEC_BASE(VBASE)) uut (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .ret_req(ret_req),
    .irq_pend(irq_pend), .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .ccr_in(ccr_in),
    .pc_out(pc_out), .x_out(x_out), .a_out(a_out), .ccr_out(ccr_out),
    .sp_out(sp_out), .grant_id(grant_id), .busy(busy), .done(done),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // RAM model: low page storage plus a computed vector table.
  logic [7:0] ram [256];
  function automatic logic [7:0] vec_byte(logic [15:0] ad);
    return ad[7:0] ^ 8'hA5;
  endfunction
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
      else mem_rdata <= (mem_addr >= VBASE) ? vec_byte(mem_addr) : ram[mem_addr[7:0]];
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic we; logic [15:0] addr; logic [7:0] data; string tag; } acc_t;
  typedef struct { logic [15:0] pc; logic [7:0] x, a, ccr, sp; int id; bit entry; int cyc; } res_t;
  typedef struct { logic [15:0] pc; logic [7:0] x, a, ccr; } frame_t;

  acc_t   acc_q[$];
  res_t   res_q[$];
  frame_t frames[$];
  logic [7:0] sp_m = 8'hFF;
  bit     mon_on = 1'b0;
  int     n_chk = 0;
  int     n_bad = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sp_dec(logic [7:0] s);
    return {2'b11, s[5:0] - 6'd1};
  endfunction
  function automatic logic [7:0] sp_inc(logic [7:0] s);
    return {2'b11, s[5:0] + 6'd1};
  endfunction

  // Monitor: pops expected accesses and results as the design produces them.
  always @(negedge clk) begin
    acc_t e;
    res_t r;
    if (mon_on) begin
      if (mem_en) begin
        if (acc_q.size() == 0) begin
          check("R6", "unexpected RAM access", 32'(mem_addr), 32'hFFFF_FFFF);
        end else begin
          e = acc_q.pop_front();
          check(e.tag, "mem_we", 32'(mem_we), 32'(e.we));
          check(e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
          if (e.we) check(e.tag, "mem_wdata", 32'(mem_wdata), 32'(e.data));
        end
      end
      if (done) begin
        if (res_q.size() == 0) begin
          check("R9", "unexpected done", 32'd1, 32'd0);
        end else begin
          r = res_q.pop_front();
          check(r.entry ? "R4" : "R7", "pc_out", 32'(pc_out), 32'(r.pc));
          check(r.entry ? "R3" : "R7", "ccr_out", 32'(ccr_out), 32'(r.ccr));
          check(r.entry ? "R3" : "R7", "x_out", 32'(x_out), 32'(r.x));
          check(r.entry ? "R3" : "R7", "a_out", 32'(a_out), 32'(r.a));
          check("R8", "sp_out", 32'(sp_out), 32'(r.sp));
          if (r.entry) check("R5", "grant_id", 32'(grant_id), 32'(r.id));
          check("R9", "done cycle", 32'(cyc), 32'(r.cyc));
        end
      end
    end
  end

  task automatic do_entry(logic [15:0] pc, logic [7:0] x, logic [7:0] a,
                          logic [7:0] ccr, logic [3:0] pend);
    bit          ok = (pend != 4'd0) && !ccr[3];
    int          id = 0;
    logic [7:0]  s = sp_m;
    logic [7:0]  d [5];
    logic [15:0] pc_before = pc_out;
    bit          seen = 1'b0;
    res_t        r;
    @(negedge clk);
    irq_pend = pend; pc_in = pc; x_in = x; a_in = a; ccr_in = ccr;
    entry_req = 1'b1;
    if (ok) begin
      for (int i = NSRC - 1; i >= 0; i--) if (pend[i]) id = i;
      d = '{pc[7:0], pc[15:8], x, a, ccr};
      for (int k = 0; k < 5; k++) begin
        acc_q.push_back('{we: 1'b1, addr: 16'(s), data: d[k], tag: "R2"});
        s = sp_dec(s);
      end
      acc_q.push_back('{we: 1'b0, addr: VBASE + 16'(2 * id), data: 8'h00, tag: "R4"});
      acc_q.push_back('{we: 1'b0, addr: VBASE + 16'(2 * id + 1), data: 8'h00, tag: "R4"});
      r.pc = {vec_byte(VBASE + 16'(2 * id)), vec_byte(VBASE + 16'(2 * id + 1))};
      r.x = x; r.a = a; r.ccr = ccr | 8'h08; r.sp = s; r.id = id;
      r.entry = 1'b1; r.cyc = cyc + 9;
      res_q.push_back(r);
      frames.push_back('{pc: pc, x: x, a: a, ccr: ccr});
      sp_m = s;
    end
    @(negedge clk);
    entry_req = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!ok && (busy || done)) seen = 1'b1;
    end
    if (!ok) begin
      // R6: ignored request leaves everything observable untouched
      check("R6", "busy/done after ignored entry", 32'(seen), 32'd0);
      check("R6", "pc_out after ignored entry", 32'(pc_out), 32'(pc_before));
    end
    check(ok ? "R8" : "R6", "sp_out after entry", 32'(sp_out), 32'(sp_m));
  endtask

  task automatic do_return();
    frame_t     f = frames.pop_back();
    logic [7:0] s = sp_m;
    res_t       r;
    @(negedge clk);
    ret_req = 1'b1;
    for (int k = 0; k < 5; k++) begin
      s = sp_inc(s);
      acc_q.push_back('{we: 1'b0, addr: 16'(s), data: 8'h00, tag: "R7"});
    end
    r.pc = f.pc; r.x = f.x; r.a = f.a; r.ccr = f.ccr; r.sp = s; r.id = 0;
    r.entry = 1'b0; r.cyc = cyc + 7;
    res_q.push_back(r);
    sp_m = s;
    @(negedge clk);
    ret_req = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    mem_rdata = 8'h00;
    rst_n = 1'b0; entry_req = 1'b0; ret_req = 1'b0; irq_pend = '0;
    pc_in = '0; x_in = '0; a_in = '0; ccr_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "sp_out after reset", 32'(sp_out), 32'hFF);
    check("R1", "busy after reset", 32'(busy), 32'd0);
    check("R1", "done after reset", 32'(done), 32'd0);
    check("R1", "mem_en after reset", 32'(mem_en), 32'd0);
    mon_on = 1'b1;

    // Two sources pending: index 1 wins (R5), then return (R7)
    do_entry(16'h1234, 8'h56, 8'h78, 8'h00, 4'b0110);
    do_return();

    // Flags preserved and the mask cleared again on return
    do_entry(16'hBEEF, 8'h11, 8'h22, 8'hE5, 4'b1000);
    do_entry(16'h4444, 8'h33, 8'h44, 8'h08, 4'b0001); // masked
    do_entry(16'h5555, 8'h66, 8'h77, 8'h00, 4'b0000); // nothing pending
    do_entry(16'hCAFE, 8'h99, 8'hAA, 8'h01, 4'b0101); // nested after I cleared
    do_return();
    do_return();

    // Fill past the bottom of the region so the pointer wraps (R8)
    for (int i = 0; i < 13; i++) begin
      do_entry(16'h1000 + 16'(i * 16'h111), 8'(i), ~8'(i),
               8'(i * 16) & 8'hF7, 4'((i % 15) + 1));
    end
    do_return();
    do_return();

    check("R9", "pending results left", 32'(res_q.size()), 32'd0);
    check("R2", "pending accesses left", 32'(acc_q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule